// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

This block sits beside a request/acknowledge bus on which one master talks to internal slaves, one transfer at a time. A transfer opens when the master pulses either its read or its write request for a single cycle. It closes when a slave answers with a one-cycle acknowledge (success) or a one-cycle error (failure). The answer may arrive in the same cycle as the request.

The monitor counts the cycles that a transfer stays open. If no answer has arrived by a parameterized limit (15 cycles by default), it drives a one-cycle error toward the master itself and closes the transfer. An access to an address that no slave decodes therefore ends in a bus error instead of hanging the master. Acknowledge and error pulses are forwarded to the master only while a transfer is open, so an answer that arrives after a timeout never reaches it.

The monitor also records the outcome of the last failed transfer in sticky status flags: whether it was a timeout or a slave error, and whether it was a read or a write. It flags two protocol faults: a new request while a transfer is still open, and a change of address, write data or byte enables while a transfer is open. All sticky flags are cleared by a dedicated clear input.

Top module: `xfer_timeout_guard`

## Requirements
- R1: A transfer opens in the cycle where `rd_req_i` or `wr_req_i` is high and none is open. `ack_o` follows `ack_i` only in that request cycle and in the cycles while the transfer stays open.
- R2: An acknowledge or error that arrives in the request cycle itself is forwarded in that same cycle and closes the transfer with zero wait.
- R3: Number the request cycle as 0. If no acknowledge or error arrives in cycles 0 to TIMEOUT_CYC, `err_o` is high for exactly cycle TIMEOUT_CYC and the transfer closes. A slave answer that arrives in cycle TIMEOUT_CYC itself wins over the timeout.
- R4: A slave error (`err_i`) during an open transfer is forwarded on `err_o` in the same cycle and closes the transfer.
- R5: An acknowledge or error that arrives while no transfer is open is ignored: `ack_o` and `err_o` stay low, and this includes answers that arrive after a timeout.
- R6: From the cycle after a transfer fails, `stat_vld_o` is 1, `stat_tmo_o` is 1 for a timeout and 0 for a slave error, and `stat_wr_o` is 1 for a write and 0 for a read. A successful transfer leaves these flags unchanged.
- R7: A `stat_clr_i` pulse clears every sticky flag from the next cycle on. A new failure or fault in the same cycle as the clear takes priority, and its flag is set.
- R8: A request that arrives while a transfer is open sets `stat_proto_o` from the next cycle. The request is otherwise ignored, and the open transfer keeps its original window.
- R9: A change of `addr_i`, `wdata_i` or `ben_i` while a transfer is open, compared with their values in the request cycle, sets `stat_stab_o` from the next cycle.
- R10: After reset no transfer is open, and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | One-cycle read request pulse from the master |
| wr_req_i | input | 1 | One-cycle write request pulse from the master |
| addr_i | input | ADDR_W | Transfer address |
| wdata_i | input | DATA_W | Write data |
| ben_i | input | DATA_W/8 | Byte enables qualifying the write data |
| ack_i | input | 1 | Slave acknowledge pulse |
| err_i | input | 1 | Slave error pulse |
| stat_clr_i | input | 1 | Clears all sticky status flags |
| ack_o | output | 1 | Acknowledge forwarded to the master |
| err_o | output | 1 | Merged slave error or timeout error to the master |
| stat_vld_o | output | 1 | A failed transfer has been recorded |
| stat_tmo_o | output | 1 | The recorded failure was a timeout (1) or a slave error (0) |
| stat_wr_o | output | 1 | The recorded failure was a write (1) or a read (0) |
| stat_proto_o | output | 1 | Sticky: a request arrived while a transfer was open |
| stat_stab_o | output | 1 | Sticky: the payload changed while a transfer was open |

## Verification
The bench sweeps the response delay from 0 to past the timeout limit, for reads and writes, with an acknowledge, a slave error and no answer. An off-by-one window would show as a timeout one cycle early or late, or as a forwarded answer in cycle TIMEOUT_CYC that should have won. An answer arriving after a timeout catches a design that does not gate late responses and passes a stray acknowledge to the master. Overlapping requests check that a design which restarts the window on any request misses the original deadline. A clear issued in the same cycle as a timeout catches wrong priority between clear and set in the status flags.

// File: rtl/xto_pkg.sv
package xto_pkg;

   // Outcome of the currently observed cycle of a transfer
   typedef enum logic [1:0] {
      XTO_NONE    = 2'd0,
      XTO_ACK     = 2'd1,
      XTO_SLVERR  = 2'd2,
      XTO_TIMEOUT = 2'd3
   } xto_outcome_e;

   function automatic logic xto_is_fail(input xto_outcome_e o);
      return (o == XTO_SLVERR) || (o == XTO_TIMEOUT);
   endfunction

endpackage

// File: rtl/xto_window.sv
module xto_window
   import xto_pkg::*;
#(
   parameter int TIMEOUT_CYC = 15,
   localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         rd_req_i,
   input  logic         wr_req_i,
   input  logic         ack_i,
   input  logic         err_i,
   output logic         busy_o,
   output logic         start_o,
   output logic         overlap_o,
   output logic         is_wr_o,
   output xto_outcome_e outcome_o
);

   logic          busy_q;
   logic          wr_q;
   logic [CW-1:0] cnt_q;
   logic          req;
   logic          resp;
   logic          live;
   logic          expire;

   assign req       = rd_req_i | wr_req_i;
   assign resp      = ack_i | err_i;
   assign start_o   = req & ~busy_q;
   assign overlap_o = req & busy_q;
   assign live      = start_o | busy_q;
   assign expire    = busy_q & ~resp & (cnt_q == CW'(TIMEOUT_CYC));
   assign is_wr_o   = start_o ? wr_req_i : wr_q;
   assign busy_o    = busy_q;

   always_comb begin
      outcome_o = XTO_NONE;
      if (live && ack_i)       outcome_o = XTO_ACK;
      else if (live && err_i)  outcome_o = XTO_SLVERR;
      else if (expire)         outcome_o = XTO_TIMEOUT;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
         cnt_q  <= '0;
      end else if (start_o && !resp) begin
         busy_q <= 1'b1;
         wr_q   <= wr_req_i;
         cnt_q  <= CW'(1);
      end else if (busy_q && (resp || expire)) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (busy_q) begin
         cnt_q  <= cnt_q + CW'(1);
      end
   end

   // R3
   cnt_in_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> (cnt_q >= CW'(1)) && (cnt_q <= CW'(TIMEOUT_CYC)));

   // R3
   timeout_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (outcome_o == XTO_TIMEOUT) |=> !busy_q);

   // R1
   open_on_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_o && !ack_i && !err_i) |=> busy_q && (cnt_q == CW'(1)));

endmodule

// File: rtl/xto_payload.sv
module xto_payload #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter bit ENABLE  = 1'b1,
   localparam int BEN_W  = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [BEN_W-1:0]  ben_i,
   output logic              mism_o
);

   generate
      if (ENABLE) begin : g_cmp
         logic [ADDR_W-1:0] addr_q;
         logic [DATA_W-1:0] wdata_q;
         logic [BEN_W-1:0]  ben_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               addr_q  <= '0;
               wdata_q <= '0;
               ben_q   <= '0;
            end else if (start_i) begin
               addr_q  <= addr_i;
               wdata_q <= wdata_i;
               ben_q   <= ben_i;
            end
         end

         assign mism_o = busy_i & ((addr_i != addr_q) | (wdata_i != wdata_q) | (ben_i != ben_q));
      end else begin : g_off
         assign mism_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/xto_status.sv
module xto_status
   import xto_pkg::*;
(
   input  logic         clk_i,
   input  logic         rst_ni,
   input  xto_outcome_e outcome_i,
   input  logic         is_wr_i,
   input  logic         overlap_i,
   input  logic         mism_i,
   input  logic         clr_i,
   output logic         vld_o,
   output logic         tmo_o,
   output logic         wr_o,
   output logic         proto_o,
   output logic         stab_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_o <= 1'b0;
         tmo_o <= 1'b0;
         wr_o  <= 1'b0;
      end else if (xto_is_fail(outcome_i)) begin
         vld_o <= 1'b1;
         tmo_o <= (outcome_i == XTO_TIMEOUT);
         wr_o  <= is_wr_i;
      end else if (clr_i) begin
         vld_o <= 1'b0;
         tmo_o <= 1'b0;
         wr_o  <= 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        proto_o <= 1'b0;
      else if (overlap_i) proto_o <= 1'b1;
      else if (clr_i)     proto_o <= 1'b0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stab_o <= 1'b0;
      else if (mism_i) stab_o <= 1'b1;
      else if (clr_i)  stab_o <= 1'b0;
   end

   // R7
   clr_wipes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && (outcome_i == XTO_NONE || outcome_i == XTO_ACK)) |=> !vld_o && !tmo_o && !wr_o);

endmodule

// File: rtl/xfer_timeout_guard.sv
module xfer_timeout_guard
   import xto_pkg::*;
#(
   parameter int TIMEOUT_CYC   = 15,
   parameter int ADDR_W        = 32,
   parameter int DATA_W        = 32,
   parameter bit PAYLOAD_CHECK = 1'b1,
   localparam int BEN_W        = DATA_W / 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              rd_req_i,
   input  logic              wr_req_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [BEN_W-1:0]  ben_i,
   input  logic              ack_i,
   input  logic              err_i,
   input  logic              stat_clr_i,
   output logic              ack_o,
   output logic              err_o,
   output logic              stat_vld_o,
   output logic              stat_tmo_o,
   output logic              stat_wr_o,
   output logic              stat_proto_o,
   output logic              stat_stab_o
);

   generate
      if (TIMEOUT_CYC < 1) begin : g_bad_limit
         $error("TIMEOUT_CYC must be at least 1");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic         win_busy;
   logic         win_start;
   logic         win_overlap;
   logic         win_is_wr;
   logic         pl_mism;
   xto_outcome_e win_outcome;

   xto_window #(
      .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_window (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_req_i  (rd_req_i),
      .wr_req_i  (wr_req_i),
      .ack_i     (ack_i),
      .err_i     (err_i),
      .busy_o    (win_busy),
      .start_o   (win_start),
      .overlap_o (win_overlap),
      .is_wr_o   (win_is_wr),
      .outcome_o (win_outcome)
   );

   xto_payload #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .ENABLE (PAYLOAD_CHECK)
   ) u_payload (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (win_start),
      .busy_i  (win_busy),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .ben_i   (ben_i),
      .mism_o  (pl_mism)
   );

   xto_status u_status (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .outcome_i (win_outcome),
      .is_wr_i   (win_is_wr),
      .overlap_i (win_overlap),
      .mism_i    (pl_mism),
      .clr_i     (stat_clr_i),
      .vld_o     (stat_vld_o),
      .tmo_o     (stat_tmo_o),
      .wr_o      (stat_wr_o),
      .proto_o   (stat_proto_o),
      .stab_o    (stat_stab_o)
   );

   assign ack_o = (win_outcome == XTO_ACK);
   assign err_o = xto_is_fail(win_outcome);

   // R5
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!win_busy && !rd_req_i && !wr_req_i) |-> !ack_o && !err_o);

   // R6
   timeout_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && !err_i) |=> stat_vld_o && stat_tmo_o);

   // R8
   overlap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (win_busy && (rd_req_i || wr_req_i)) |=> stat_proto_o);

   // R9
   payload_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (PAYLOAD_CHECK && $rose(win_busy) && !$stable(addr_i)) |=> stat_stab_o);

   // R2
   one_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ack_o && err_o));

endmodule

// File: tb/xfer_timeout_guard_bench.sv
`timescale 1ns/1ps
module xfer_timeout_guard_bench;

   localparam int LIM = 15;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        rd_req_i = 1'b0;
   logic        wr_req_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [3:0]  ben_i = '0;
   logic        ack_i = 1'b0;
   logic        err_i = 1'b0;
   logic        stat_clr_i = 1'b0;
   logic        ack_o, err_o, stat_vld_o, stat_tmo_o, stat_wr_o, stat_proto_o, stat_stab_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk_i = ~clk_i;

   xfer_timeout_guard #(
      .TIMEOUT_CYC(LIM)
   ) u_xfer_timeout_guard (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .rd_req_i     (rd_req_i),
      .wr_req_i     (wr_req_i),
      .addr_i       (addr_i),
      .wdata_i      (wdata_i),
      .ben_i        (ben_i),
      .ack_i        (ack_i),
      .err_i        (err_i),
      .stat_clr_i   (stat_clr_i),
      .ack_o        (ack_o),
      .err_o        (err_o),
      .stat_vld_o   (stat_vld_o),
      .stat_tmo_o   (stat_tmo_o),
      .stat_wr_o    (stat_wr_o),
      .stat_proto_o (stat_proto_o),
      .stat_stab_o  (stat_stab_o)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] stat_vec();
      return {3'b0, stat_vld_o, stat_tmo_o, stat_wr_o, stat_proto_o, stat_stab_o};
   endfunction

   task automatic clr_pulse();
      @(negedge clk_i);
      stat_clr_i = 1'b1;
      @(negedge clk_i);
      stat_clr_i = 1'b0;
   endtask

   // kind: 0 = acknowledge, 1 = slave error, 2 = no answer
   task automatic run_xfer(input bit is_wr, input int kind, input int dly);
      int  last;
      bit  resolved;
      bit  fail_out;
      logic [7:0] st;
      string tg;
      resolved = (kind != 2) && (dly <= LIM);
      last = ((dly > LIM) ? dly : LIM) + 1;
      clr_pulse();
      addr_i  = 32'h4000_0000 + 32'(dly * 4);
      wdata_i = 32'hA5A5_0000 + 32'(kind);
      ben_i   = 4'hF;
      for (int c = 0; c <= last; c++) begin
         bit eack;
         bit eerr;
         @(negedge clk_i);
         rd_req_i = (c == 0) && !is_wr;
         wr_req_i = (c == 0) && is_wr;
         ack_i    = (kind == 0) && (c == dly);
         err_i    = (kind == 1) && (c == dly);
         #1;
         eack = resolved && (kind == 0) && (c == dly);
         eerr = (resolved && (kind == 1) && (c == dly)) || (!resolved && (c == LIM));
         if (c == 0 && dly == 0)           tg = "R2 zero-wait answer";
         else if (!resolved && c > LIM)   tg = "R5 late answer ignored";
         else if (!resolved)              tg = "R3 timeout window";
         else if (kind == 1)              tg = "R4 slave error forwarded";
         else                             tg = "R1 acknowledge forwarded";
         check(tg, {6'b0, ack_o, err_o}, {6'b0, eack, eerr});
      end
      @(negedge clk_i);
      rd_req_i = 1'b0; wr_req_i = 1'b0; ack_i = 1'b0; err_i = 1'b0;
      #1;
      fail_out = !resolved || (kind == 1);
      st = {3'b0, fail_out, !resolved, fail_out && is_wr, 1'b0, 1'b0};
      check("R6 status after transfer", stat_vec(), st);
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      #1;
      // R10
      check("R10 reset outputs", {1'b0, ack_o, err_o, stat_vld_o, stat_tmo_o, stat_wr_o, stat_proto_o, stat_stab_o}, 8'h00);

      // R5: answers with no open transfer
      @(negedge clk_i); ack_i = 1'b1; #1;
      check("R5 idle acknowledge", {6'b0, ack_o, err_o}, 8'h00);
      @(negedge clk_i); ack_i = 1'b0; err_i = 1'b1; #1;
      check("R5 idle error", {6'b0, ack_o, err_o}, 8'h00);
      @(negedge clk_i); err_i = 1'b0; #1;
      check("R5 idle leaves status", stat_vec(), 8'h00);

      // Sweep of response delay, direction and answer type
      for (int w = 0; w < 2; w++)
         for (int k = 0; k < 3; k++)
            for (int d = 0; d <= LIM + 2; d++)
               run_xfer(w[0], k, d);

      // R8: overlapping request keeps the first window
      clr_pulse();
      addr_i = 32'h8000_0010; wdata_i = 32'h1; ben_i = 4'h3;
      for (int c = 0; c <= LIM + 1; c++) begin
         @(negedge clk_i);
         rd_req_i = (c == 0);
         wr_req_i = (c == 2);
         #1;
         if (c == 3) check("R8 overlap flag", {7'b0, stat_proto_o}, 8'h01);
         check("R8 original window kept", {6'b0, ack_o, err_o}, {6'b0, 1'b0, (c == LIM)});
      end
      @(negedge clk_i); rd_req_i = 1'b0; wr_req_i = 1'b0; #1;
      check("R8 status after overlap timeout", stat_vec(), 8'b0001_1010);

      // R7: clear wipes all flags
      clr_pulse();
      #1;
      check("R7 clear wipes flags", stat_vec(), 8'h00);

      // R9: payload change while open
      @(negedge clk_i);
      wr_req_i = 1'b1; addr_i = 32'h8000_0020; wdata_i = 32'hDEAD_BEEF; ben_i = 4'hC;
      @(negedge clk_i); wr_req_i = 1'b0;
      @(negedge clk_i);
      @(negedge clk_i); ben_i = 4'h4;
      @(negedge clk_i); #1;
      check("R9 payload change flag", {7'b0, stat_stab_o}, 8'h01);
      ack_i = 1'b1; #1;
      check("R1 acknowledge after payload change", {6'b0, ack_o, err_o}, 8'h02);
      @(negedge clk_i); ack_i = 1'b0; #1;
      check("R6 acknowledge leaves failure status clear", {5'b0, stat_vld_o, stat_tmo_o, stat_wr_o}, 8'h00);

      // R9: stable payload raises nothing
      clr_pulse();
      @(negedge clk_i); rd_req_i = 1'b1; addr_i = 32'h8000_0030;
      @(negedge clk_i); rd_req_i = 1'b0;
      @(negedge clk_i); ack_i = 1'b1;
      @(negedge clk_i); ack_i = 1'b0; #1;
      check("R9 stable payload no flag", stat_vec(), 8'h00);

      // R7: timeout in the same cycle as clear wins
      @(negedge clk_i); wr_req_i = 1'b1;
      for (int c = 1; c <= LIM; c++) begin
         @(negedge clk_i);
         wr_req_i = 1'b0;
         stat_clr_i = (c == LIM);
      end
      #1;
      check("R7 timeout at clear cycle", {6'b0, ack_o, err_o}, 8'h01);
      @(negedge clk_i); stat_clr_i = 1'b0; #1;
      check("R7 set wins over clear", stat_vec(), 8'b0001_1100);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule